// File: doc/BRIEF.md
# Branch Condition and Flag Evaluator

This unit holds the four condition flags of a processor: negative, zero, carry and overflow. Each time an add or subtract executes, the unit receives the two operands, the operation type and the result that the datapath produced. When the instruction is one that sets flags, the unit derives the four flags and stores them in a register.

In the same cycle, the unit decides whether a branch is taken. The kinds of branch are:

- a conditional branch, which tests the stored flags with a 4-bit condition code;
- a branch that tests whether a register is zero;
- a branch that tests whether a register is non-zero;
- an unconditional branch.

A conditional branch always reads the flags as left by the most recent earlier flag-setting instruction. Flags that are being written in the current cycle do not affect the decision.

Top module: `branch_eval`

## Requirements
- R1: After reset, the flags register `flags_q` is 4'b0000. Its bit layout is {N,Z,C,V}, with N at bit 3, Z at bit 2, C at bit 1 and V at bit 0.
- R2: On a clock edge with `set_flags` high, N takes the result's sign bit, and Z is 1 exactly when the result is all zeros.
- R3: For an add (`is_sub`=0), V is 1 in two cases: both operands are non-negative and the result sign is 1, or both operands are negative and the result sign is 0. Operands of opposite sign give V=0.
- R4: For a subtract (`is_sub`=1), operands of the same sign give V=0. A non-negative minus a negative gives V=1 when the result sign is 1. A negative minus a non-negative gives V=1 when the result sign is 0.
- R5: For an add, C is the unsigned carry out of the operand sum. For a subtract, C is 1 when no borrow occurs, that is, when `op_a` >= `op_b` as unsigned numbers.
- R6: While `set_flags` is low, `flags_q` keeps its value across clock edges.
- R7: With `br_kind`=0, the simple condition codes decide `taken` as follows: 0 EQ (Z), 1 NE (!Z), 4 MI (N), 5 PL (!N), 6 VS (V), 7 VC (!V). Codes 14 and 15 always give `taken`=1.
- R8: With `br_kind`=0, the signed condition codes decide `taken` as follows: 11 LT (N^V), 13 LE (Z|(N^V)), 10 GE (!(N^V)), 12 GT (!Z & !(N^V)).
- R9: With `br_kind`=0, the unsigned condition codes decide `taken` as follows: 3 LO (!C), 9 LS (!C|Z), 2 HS (C), 8 HI (C&!Z).
- R10: With `br_kind`=1, `taken` is 1 exactly when `reg_val` is zero. With `br_kind`=2, `taken` is 1 exactly when `reg_val` is non-zero. With `br_kind`=3, `taken` is always 1.
- R11: A conditional branch uses `flags_q` as it stood before the current edge. Flags being set in the same cycle do not change `taken` until after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| op_a | input | WIDTH | First operand |
| op_b | input | WIDTH | Second operand |
| is_sub | input | 1 | 1 selects subtract, 0 selects add |
| result | input | WIDTH | Result produced by the datapath |
| set_flags | input | 1 | When high, the flags register is written at the next edge |
| cond | input | 4 | Condition code for a conditional branch |
| br_kind | input | 2 | 0 conditional, 1 register zero, 2 register non-zero, 3 always |
| reg_val | input | WIDTH | Register value tested by branch kinds 1 and 2 |
| taken | output | 1 | Branch decision |
| flags_q | output | 4 | Stored flags {N,Z,C,V} |

## Verification
The bench builds the block with the default WIDTH of 64.

- Directed cases place the operands at the signed extremes, such as the most positive value plus one and the most negative value minus one, so that the sign-bit overflow rules and the carry/borrow boundary are each hit.
- Random operands are paired sometimes with the true result and sometimes with an unrelated result. This exercises every combination of operand sign and result sign.
- Each stored flag pattern is swept across all sixteen condition codes.

// File: rtl/branch_eval.sv
module branch_eval #(
  parameter int WIDTH = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] op_a,
  input  logic [WIDTH-1:0] op_b,
  input  logic             is_sub,
  input  logic [WIDTH-1:0] result,
  input  logic             set_flags,
  input  logic [3:0]       cond,
  input  logic [1:0]       br_kind,
  input  logic [WIDTH-1:0] reg_val,
  output logic             taken,
  output logic [3:0]       flags_q
);
  localparam int MSB = WIDTH - 1;

  logic [WIDTH:0] sum_ext;
  logic           a_s, b_s, r_s;
  logic           n_new, z_new, c_new, v_new;
  logic           n, z, c, v;
  logic           base, cond_ok;

  assign sum_ext = {1'b0, op_a} + {1'b0, is_sub ? ~op_b : op_b} + {{WIDTH{1'b0}}, is_sub};
  assign a_s = op_a[MSB];
  assign b_s = op_b[MSB];
  assign r_s = result[MSB];

  assign n_new = r_s;
  assign z_new = (result == '0);
  assign c_new = sum_ext[WIDTH];
  assign v_new = is_sub ? ((a_s != b_s) && (r_s != a_s))
                        : ((a_s == b_s) && (r_s != a_s));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         flags_q <= 4'b0000;
    else if (set_flags) flags_q <= {n_new, z_new, c_new, v_new};
  end

  assign {n, z, c, v} = flags_q;

  always_comb begin
    case (cond[3:1])
      3'd0:    base = z;
      3'd1:    base = c;
      3'd2:    base = n;
      3'd3:    base = v;
      3'd4:    base = c && !z;
      3'd5:    base = (n == v);
      3'd6:    base = !z && (n == v);
      default: base = 1'b1;
    endcase
    cond_ok = (cond[3:1] == 3'd7) ? 1'b1 : (base ^ cond[0]);
  end

  always_comb begin
    case (br_kind)
      2'd0:    taken = cond_ok;
      2'd1:    taken = (reg_val == '0);
      2'd2:    taken = (reg_val != '0);
      default: taken = 1'b1;
    endcase
  end
endmodule

// File: rtl/branch_eval_checker.sv
module branch_eval_checker #(
  parameter int WIDTH = 64
) (
  input logic             clk,
  input logic             rst_n,
  input logic [WIDTH-1:0] op_a,
  input logic [WIDTH-1:0] op_b,
  input logic             is_sub,
  input logic [WIDTH-1:0] result,
  input logic             set_flags,
  input logic [3:0]       cond,
  input logic [1:0]       br_kind,
  input logic [WIDTH-1:0] reg_val,
  input logic             taken,
  input logic [3:0]       flags_q
);
  localparam int MSB = WIDTH - 1;

  always_comb if (!rst_n) assert_reset_clear_R1: assert (flags_q == 4'b0000);

  assert_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !set_flags |=> $stable(flags_q));

  assert_zero_flag_R2: assert property (@(posedge clk) disable iff (!rst_n)
    set_flags |=> (flags_q[2] == ($past(result) == '0)) && (flags_q[3] == $past(result[MSB])));

  assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (set_flags && !is_sub && (op_a[MSB] != op_b[MSB])) |=> !flags_q[0]);

  assert_no_overflow_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (set_flags && is_sub && (op_a[MSB] == op_b[MSB])) |=> !flags_q[0]);

  assert_reg_test_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (br_kind == 2'd1 && reg_val == '0) || (br_kind == 2'd2 && reg_val != '0) || br_kind == 2'd3
      |-> taken);

  assert_reg_miss_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (br_kind == 2'd1 && reg_val != '0) || (br_kind == 2'd2 && reg_val == '0) |-> !taken);

  assert_always_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (br_kind == 2'd0 && cond[3:1] == 3'd7) |-> taken);
endmodule

bind branch_eval branch_eval_checker #(.WIDTH(WIDTH)) chk_i (.*);

// File: tb/branch_eval_tb_top.sv
module branch_eval_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int W = 64;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [W-1:0] op_a = '0, op_b = '0, result = '0, reg_val = '0;
  logic         is_sub = 1'b0, set_flags = 1'b0;
  logic [3:0]   cond = 4'd0;
  logic [1:0]   br_kind = 2'd0;
  logic         taken;
  logic [3:0]   flags_q;

  int checks = 0;
  int errors = 0;
  logic [3:0] mflags = 4'b0000;

  always #(CLK_PERIOD/2) clk = ~clk;

  branch_eval #(.WIDTH(W)) dut_i (
    .clk(clk), .rst_n(rst_n), .op_a(op_a), .op_b(op_b), .is_sub(is_sub),
    .result(result), .set_flags(set_flags), .cond(cond), .br_kind(br_kind),
    .reg_val(reg_val), .taken(taken), .flags_q(flags_q)
  );

  task automatic check(input bit ok, input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [3:0] model_flags(input logic [W-1:0] a, input logic [W-1:0] b,
                                             input logic sub, input logic [W-1:0] r);
    logic n, z, c, v;
    logic [W:0] s;
    n = r[W-1];
    z = (r == 0);
    if (sub) c = (a >= b);
    else begin
      s = {1'b0, a} + {1'b0, b};
      c = s[W];
    end
    if (!sub) v = (!a[W-1] && !b[W-1] && r[W-1]) || (a[W-1] && b[W-1] && !r[W-1]);
    else      v = (!a[W-1] && b[W-1] && r[W-1]) || (a[W-1] && !b[W-1] && !r[W-1]);
    return {n, z, c, v};
  endfunction

  function automatic logic model_cond(input logic [3:0] f, input logic [3:0] cc);
    logic n, z, c, v;
    {n, z, c, v} = f;
    case (cc)
      4'd0:  return z;
      4'd1:  return !z;
      4'd2:  return c;
      4'd3:  return !c;
      4'd4:  return n;
      4'd5:  return !n;
      4'd6:  return v;
      4'd7:  return !v;
      4'd8:  return c && !z;
      4'd9:  return !c || z;
      4'd10: return n == v;
      4'd11: return n != v;
      4'd12: return !z && (n == v);
      4'd13: return z || (n != v);
      default: return 1'b1;
    endcase
  endfunction

  function automatic string cond_req(input logic [3:0] cc);
    case (cc)
      4'd2, 4'd3, 4'd8, 4'd9:     return "R9";
      4'd10, 4'd11, 4'd12, 4'd13: return "R8";
      default:                    return "R7";
    endcase
  endfunction

  task automatic apply_op(input logic [W-1:0] a, input logic [W-1:0] b, input logic sub,
                          input logic [W-1:0] r, input logic sf);
    logic [3:0] expf;
    @(negedge clk);
    op_a = a; op_b = b; is_sub = sub; result = r; set_flags = sf;
    br_kind = 2'd0; cond = 4'd0;
    #1;
    check(taken == mflags[2], "R11", W'(taken), W'(mflags[2]));
    @(posedge clk);
    #1;
    expf = model_flags(a, b, sub, r);
    if (sf) begin
      check(flags_q[3:2] == expf[3:2], "R2", W'(flags_q), W'(expf));
      check(flags_q[0] == expf[0], sub ? "R4" : "R3", W'(flags_q), W'(expf));
      check(flags_q[1] == expf[1], "R5", W'(flags_q), W'(expf));
      mflags = expf;
    end else begin
      check(flags_q == mflags, "R6", W'(flags_q), W'(mflags));
    end
    @(negedge clk);
    set_flags = 1'b0;
  endtask

  task automatic sweep_conds();
    for (int k = 0; k < 16; k++) begin
      cond = 4'(k);
      br_kind = 2'd0;
      #1;
      check(taken == model_cond(mflags, cond), cond_req(cond), W'(taken), W'(model_cond(mflags, cond)));
    end
  endtask

  task automatic reg_branches(input logic [W-1:0] rv);
    reg_val = rv;
    br_kind = 2'd1; #1;
    check(taken == (rv == 0), "R10", W'(taken), W'(rv == 0));
    br_kind = 2'd2; #1;
    check(taken == (rv != 0), "R10", W'(taken), W'(rv != 0));
    br_kind = 2'd3; #1;
    check(taken == 1'b1, "R10", W'(taken), 1);
    br_kind = 2'd0;
  endtask

  localparam logic [W-1:0] MAXP = {1'b0, {(W-1){1'b1}}};
  localparam logic [W-1:0] MINN = {1'b1, {(W-1){1'b0}}};

  initial begin
    logic [W-1:0] a, b, r;
    logic         s;
    void'($urandom(32'd2024));
    #(CLK_PERIOD*2 + 1);
    check(flags_q == 4'b0000, "R1", W'(flags_q), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(flags_q == 4'b0000, "R1", W'(flags_q), 0);
    sweep_conds();
    reg_branches('0);

    apply_op(MAXP, 1, 1'b0, MAXP + 1, 1'b1);        sweep_conds();
    apply_op(MINN, MINN, 1'b0, MINN + MINN, 1'b1);  sweep_conds();
    apply_op(MAXP, MINN, 1'b0, MAXP + MINN, 1'b1);  sweep_conds();
    apply_op('0, 1, 1'b1, '0 - 1, 1'b1);            sweep_conds();
    apply_op(5, 5, 1'b1, 0, 1'b1);                  sweep_conds();
    apply_op(MINN, 1, 1'b1, MINN - 1, 1'b1);        sweep_conds();
    apply_op('0, MINN, 1'b1, '0 - MINN, 1'b1);      sweep_conds();
    apply_op({W{1'b1}}, 1, 1'b0, 0, 1'b1);          sweep_conds();
    apply_op(3, 7, 1'b1, 3 - 7, 1'b0);              sweep_conds();
    reg_branches(1);
    reg_branches(MINN);

    for (int i = 0; i < 400; i++) begin
      a = {$urandom(), $urandom()};
      b = {$urandom(), $urandom()};
      if ($urandom_range(0, 3) == 0) b = a;
      s = 1'($urandom_range(0, 1));
      r = s ? a - b : a + b;
      if ($urandom_range(0, 3) == 0) r = {$urandom(), $urandom()};
      apply_op(a, b, s, r, $urandom_range(0, 4) != 0);
      sweep_conds();
      reg_branches(($urandom_range(0, 2) == 0) ? '0 : {$urandom(), $urandom()});
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule